// File: doc/BRIEF.md
# Serial Transmitter with Half-Duplex Line Turnaround

This block is the transmit side of an asynchronous serial port. A host pushes bytes with a one-cycle write strobe into a 64-entry queue. A shift stage takes each byte from the queue and sends it as a fixed frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line idles high. Bit time is counted in pulses of an oversampling tick input, at 16 or 8 pulses per bit, chosen by a mode input.

Two flags report progress. One shows that the queue is empty. The other shows that the shift stage is empty, which means the final stop bit has fully left the pin. A level interrupt, gated by an enable input, reports that the transmitter needs data.

For a shared two-wire bus, a direction-control mode drives an output high while characters are being sent. After the last stop bit, the output stays high for a further 0 to 15 bit times before it falls. This gives the last character time to reach distant stations before the line driver turns off. In this mode the interrupt follows the shift-stage-empty condition, so software is not told too early that it can turn the line around.

Top module: `serial_tx_turnaround`

## Requirements
- R1: Accepted bytes are sent in write order, and the queue holds at most 64 bytes. A write made while the queue holds 64 bytes is dropped, and `ovf_pulse` is high for exactly the one clock that follows that write.
- R2: Each frame has a start bit of 0, then data bits 0 to 7 in that order, then a stop bit of 1. Each bit lasts 16 `os_tick` pulses when `half_rate`=0 and 8 pulses when `half_rate`=1. `txd` is 1 whenever no frame is in progress.
- R3: `hold_empty` is 1 exactly when the queue holds no bytes.
- R4: `shift_empty` falls in the clock after a byte leaves a non-empty queue. It rises on the edge that consumes the last tick of the stop bit, and it stays 1 for at least one clock between frames.
- R5: With `dir_en`=0 and `irq_en`=1, `irq` is 1 exactly when the queue count is below `trig_level` or is zero.
- R6: With `dir_en`=1 and `irq_en`=1, `irq` is 1 exactly when `hold_empty` and `shift_empty` are both 1.
- R7: With `irq_en`=0, `irq` is 0.
- R8: With `dir_en`=1, `dir_out` rises on the edge that accepts a write and stays 1 while a frame is in progress or the queue is not empty. With `dir_en`=0, `dir_out` is 0.
- R9: When the last frame ends with the queue empty, `dir_out` falls after exactly `turn_delay` times the bit length in `os_tick` pulses have been consumed. When `turn_delay`=0, it falls on the same edge on which `shift_empty` rises.
- R10: A write accepted during the turnaround wait cancels the wait, and `dir_out` stays 1 through the next frame.
- R11: After reset, `txd`=1, `hold_empty`=1, `shift_empty`=1, `dir_out`=0 and `ovf_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one byte per clock |
| wr_data | input | 8 | Byte to queue |
| os_tick | input | 1 | Oversampling tick enable |
| half_rate | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| dir_en | input | 1 | Enables half-duplex direction control |
| turn_delay | input | 4 | Turnaround delay in bit times (0 to 15) |
| trig_level | input | 7 | Interrupt threshold on the queue count (0 to 64) |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial data out |
| dir_out | output | 1 | Line driver direction, 1 while transmitting |
| hold_empty | output | 1 | Queue empty flag |
| shift_empty | output | 1 | Shift stage empty flag |
| irq | output | 1 | Transmit interrupt, level |
| ovf_pulse | output | 1 | One-clock pulse for a dropped write |

## Verification
The bound checker watches several rules on every clock. It checks that the line is high whenever the shift stage is empty, and that the stage only empties right after a high stop bit. It checks that the stage only starts a frame when the queue is not empty, and that a drop pulse always follows a write to a non-empty queue. It also checks that the direction output stays high while a frame shifts or when a write arrives, and that the interrupt in direction mode never fires while anything is left to send. Other behaviour can only be shown by the bench's scenarios: bit order and bit length in both tick ratios, the exact number of ticks before the direction output falls, the cancelled countdown, the threshold interrupt as the queue drains, and the full-queue drop after 64 stored bytes plus one in the shifter.

// File: rtl/tx485_pkg.sv
package tx485_pkg;

    localparam int unsigned TICK_W = 4;

    typedef enum logic [1:0] {
        DIR_IDLE   = 2'd0,
        DIR_ACTIVE = 2'd1,
        DIR_HOLD   = 2'd2
    } dir_state_e;

    // last tick index inside one bit time
    function automatic logic [TICK_W-1:0] bit_tick_limit(input logic half_rate);
        return half_rate ? TICK_W'(7) : TICK_W'(15);
    endfunction

endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CW-1:0]     count,
    output logic              push_ok,
    output logic              ovf_pulse
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
        logic          ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + AW'(1);
    endfunction

    assign push_ok = push_req && (ctl_q.count != FULL_CNT);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ovf = push_req && !push_ok;
        if (push_ok) begin
            ctl_d.wptr = step_ptr(ctl_q.wptr);
        end
        if (pop) begin
            ctl_d.rptr = step_ptr(ctl_q.rptr);
        end
        case ({push_ok, pop})
            2'b10:   ctl_d.count = ctl_q.count + CW'(1);
            2'b01:   ctl_d.count = ctl_q.count - CW'(1);
            default: ctl_d.count = ctl_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[ctl_q.wptr] <= push_data;
        end
    end

    assign head_data = mem_q[ctl_q.rptr];
    assign count     = ctl_q.count;
    assign ovf_pulse = ctl_q.ovf;

endmodule

// File: rtl/tx_bit_engine.sv
module tx_bit_engine
    import tx485_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned FB    = DATA_W + 2,
    localparam int unsigned BW    = $clog2(FB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              os_tick,
    input  logic              half_rate,
    output logic              busy,
    output logic              txd,
    output logic              frame_done
);

    typedef struct packed {
        logic              busy;
        logic [FB-1:0]     shreg;
        logic [BW-1:0]     bits_left;
        logic [TICK_W-1:0] tick;
    } eng_t;

    eng_t st_d, st_q;
    logic [TICK_W-1:0] lim;
    logic              bit_end;

    assign lim        = bit_tick_limit(half_rate);
    assign bit_end    = st_q.busy && os_tick && (st_q.tick == lim);
    assign frame_done = bit_end && (st_q.bits_left == '0);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load) begin
                st_d.busy      = 1'b1;
                st_d.shreg     = {1'b1, load_data, 1'b0};
                st_d.bits_left = BW'(FB - 1);
                st_d.tick      = '0;
            end
        end else if (os_tick) begin
            if (st_q.tick == lim) begin
                st_d.tick = '0;
                if (st_q.bits_left == '0) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.shreg     = {1'b1, st_q.shreg[FB-1:1]};
                    st_d.bits_left = st_q.bits_left - BW'(1);
                end
            end else begin
                st_d.tick = st_q.tick + TICK_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.shreg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign txd  = !st_q.busy || st_q.shreg[0];

endmodule

// File: rtl/tx_dir_turnaround.sv
module tx_dir_turnaround
    import tx485_pkg::*;
#(
    parameter int unsigned DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_en,
    input  logic [DLY_W-1:0] turn_delay,
    input  logic             os_tick,
    input  logic             half_rate,
    input  logic             busy,
    input  logic             fifo_nonempty,
    input  logic             wr_accept,
    input  logic             frame_done,
    output logic             dir_out
);

    typedef struct packed {
        dir_state_e        state;
        logic [DLY_W-1:0]  hcnt;
        logic [TICK_W-1:0] tick;
    } dir_t;

    dir_t st_d, st_q;
    logic [TICK_W-1:0] lim;
    logic              nothing_left;

    assign lim          = bit_tick_limit(half_rate);
    assign nothing_left = !fifo_nonempty && !wr_accept;

    always_comb begin
        st_d = st_q;
        if (!dir_en) begin
            st_d.state = DIR_IDLE;
            st_d.hcnt  = '0;
            st_d.tick  = '0;
        end else begin
            case (st_q.state)
                DIR_IDLE: begin
                    if (wr_accept || busy || fifo_nonempty) begin
                        st_d.state = DIR_ACTIVE;
                    end
                end
                DIR_ACTIVE: begin
                    if (frame_done && nothing_left) begin
                        st_d.tick = '0;
                        st_d.hcnt = turn_delay;
                        st_d.state = (turn_delay == '0) ? DIR_IDLE : DIR_HOLD;
                    end else if (!busy && nothing_left) begin
                        st_d.state = DIR_IDLE;
                    end
                end
                DIR_HOLD: begin
                    if (wr_accept) begin
                        st_d.state = DIR_ACTIVE;
                    end else if (os_tick) begin
                        if (st_q.tick == lim) begin
                            st_d.tick = '0;
                            st_d.hcnt = st_q.hcnt - DLY_W'(1);
                            if (st_q.hcnt == DLY_W'(1)) begin
                                st_d.state = DIR_IDLE;
                            end
                        end else begin
                            st_d.tick = st_q.tick + TICK_W'(1);
                        end
                    end
                end
                default: st_d.state = DIR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= DIR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_out = (st_q.state != DIR_IDLE);

endmodule

// File: rtl/serial_tx_turnaround.sv
module serial_tx_turnaround #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DLY_W  = 4,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              os_tick,
    input  logic              half_rate,
    input  logic              dir_en,
    input  logic [DLY_W-1:0]  turn_delay,
    input  logic [CW-1:0]     trig_level,
    input  logic              irq_en,
    output logic              txd,
    output logic              dir_out,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              irq,
    output logic              ovf_pulse
);

    logic [DATA_W-1:0] head_data;
    logic [CW-1:0]     fill;
    logic              push_ok;
    logic              busy;
    logic              frame_done;
    logic              load;
    logic              below_trig;
    logic              all_drained;

    assign load = !busy && (fill != '0);

    tx_fifo_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (wr_en),
        .push_data (wr_data),
        .pop       (load),
        .head_data (head_data),
        .count     (fill),
        .push_ok   (push_ok),
        .ovf_pulse (ovf_pulse)
    );

    tx_bit_engine #(
        .DATA_W (DATA_W)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_data  (head_data),
        .os_tick    (os_tick),
        .half_rate  (half_rate),
        .busy       (busy),
        .txd        (txd),
        .frame_done (frame_done)
    );

    tx_dir_turnaround #(
        .DLY_W (DLY_W)
    ) dir_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .dir_en        (dir_en),
        .turn_delay    (turn_delay),
        .os_tick       (os_tick),
        .half_rate     (half_rate),
        .busy          (busy),
        .fifo_nonempty (fill != '0),
        .wr_accept     (push_ok),
        .frame_done    (frame_done),
        .dir_out       (dir_out)
    );

    assign hold_empty  = (fill == '0);
    assign shift_empty = !busy;
    assign below_trig  = (fill < trig_level) || hold_empty;
    assign all_drained = hold_empty && shift_empty;
    assign irq         = irq_en && (dir_en ? all_drained : below_trig);

endmodule

// File: rtl/tx485_checker.sv
module tx485_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic dir_en,
    input logic txd,
    input logic dir_out,
    input logic hold_empty,
    input logic shift_empty,
    input logic irq,
    input logic ovf_pulse
);

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);

    // R4
    stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_empty) |-> $past(txd));

    // R4
    load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> $past(!hold_empty));

    // R1
    ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ($past(wr_en) && $past(!hold_empty)));

    // R8
    dir_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_en && !shift_empty) |-> dir_out);

    // R6
    rs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_en && irq) |-> (shift_empty && hold_empty));

    // R10
    dir_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dir_en) && dir_en && $past(dir_out) && $past(wr_en)) |-> dir_out);

endmodule

bind serial_tx_turnaround tx485_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .dir_en      (dir_en),
    .txd         (txd),
    .dir_out     (dir_out),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty),
    .irq         (irq),
    .ovf_pulse   (ovf_pulse)
);

// File: tb/serial_tx_turnaround_tb.sv
module serial_tx_turnaround_tb_top;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       os_tick;
    logic       half_rate;
    logic       dir_en;
    logic [3:0] turn_delay;
    logic [6:0] trig_level;
    logic       irq_en;
    logic       txd, dir_out, hold_empty, shift_empty, irq, ovf_pulse;

    always #10 clk = ~clk;

    serial_tx_turnaround dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .os_tick (os_tick), .half_rate (half_rate), .dir_en (dir_en),
        .turn_delay (turn_delay), .trig_level (trig_level), .irq_en (irq_en),
        .txd (txd), .dir_out (dir_out), .hold_empty (hold_empty),
        .shift_empty (shift_empty), .irq (irq), .ovf_pulse (ovf_pulse)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int divisor(input bit hr);
        return hr ? 8 : 16;
    endfunction

    function automatic bit exp_irq(input bit en, input bit rs, input int fill,
                                   input bit sh_empty, input int trig);
        if (!en) return 1'b0;
        if (rs)  return sh_empty && (fill == 0);
        return (fill < trig) || (fill == 0);
    endfunction

    // tick generator
    int tick_per = 1;
    int tick_ph  = 0;
    initial begin
        os_tick = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (tick_per == 0) begin
                os_tick = 1'b0;
            end else begin
                tick_ph = (tick_ph + 1) % tick_per;
                os_tick = (tick_ph == 0);
            end
        end
    end

    // reference model, updated at every falling edge
    bit       model_on = 1'b0;
    int       mc;
    byte      q[$];
    bit       in_frame;
    int       tcnt;
    int       cur_div;
    byte      cur_byte;
    bit [9:0] bits;
    bit       prev_tick;
    int       dst;        // 0 idle, 1 active, 2 hold
    int       hold_rem;
    int       ovf_seen;

    always @(negedge clk) begin : mon
        bit acc;
        bit fend;
        if (!rst_n || !model_on) begin
            mc = 0; q.delete(); in_frame = 0; tcnt = 0; prev_tick = 0;
            dst = 0; hold_rem = 0; ovf_seen = 0; cur_div = 16;
        end else begin
            acc  = 1'b0;
            fend = 1'b0;
            // R1: write consumed at the edge just passed
            if (wr_en) begin
                acc = (mc < DEPTH);
                check(ovf_pulse == !acc, "R1 overflow pulse", int'(ovf_pulse), int'(!acc));
                if (acc) begin
                    q.push_back(wr_data);
                    mc++;
                end else begin
                    ovf_seen++;
                end
            end else begin
                check(ovf_pulse == 1'b0, "R1 no overflow pulse", int'(ovf_pulse), 0);
            end
            // R2: frame timing and content
            if (in_frame && prev_tick) begin
                tcnt++;
                if (tcnt % cur_div == cur_div / 2)
                    bits[tcnt / cur_div] = txd;
                if (tcnt == 10 * cur_div) begin
                    in_frame = 0;
                    fend     = 1'b1;
                    check(bits[0] == 1'b0, "R2 start bit", int'(bits[0]), 0);
                    check(bits[9] == 1'b1, "R2 stop bit", int'(bits[9]), 1);
                    check(bits[8:1] == cur_byte, "R1/R2 data byte", int'(bits[8:1]), int'(cur_byte));
                end
            end
            // direction model
            if (!dir_en) begin
                dst = 0;
            end else if (dst == 2) begin
                if (acc) dst = 1;
                else if (prev_tick) begin
                    hold_rem--;
                    if (hold_rem == 0) dst = 0;
                end
            end else if (dst == 0) begin
                if (acc) dst = 1;
            end else if (fend && mc == 0) begin
                hold_rem = int'(turn_delay) * cur_div;
                dst = (hold_rem == 0) ? 0 : 2;
            end
            // frame start
            if (!in_frame && !fend && txd === 1'b0) begin
                check(mc > 0, "R1 load from non-empty queue", mc, 1);
                if (q.size() > 0) cur_byte = q.pop_front();
                if (mc > 0) mc--;
                in_frame = 1;
                tcnt     = 0;
                cur_div  = divisor(half_rate);
                bits     = '0;
            end
            if (!in_frame)
                check(txd == 1'b1, "R2 idle line high", int'(txd), 1);
            check(shift_empty == !in_frame, "R4 shift empty", int'(shift_empty), int'(!in_frame));
            check(hold_empty == (mc == 0), "R3 holding empty", int'(hold_empty), int'(mc == 0));
            check(irq == exp_irq(irq_en, dir_en, mc, !in_frame, int'(trig_level)),
                  !irq_en ? "R7 irq gated" : (dir_en ? "R6 irq shift source" : "R5 irq trigger"),
                  int'(irq), int'(exp_irq(irq_en, dir_en, mc, !in_frame, int'(trig_level))));
            check(dir_out == (dst != 0), "R8/R9/R10 direction", int'(dir_out), int'(dst != 0));
        end
        prev_tick = os_tick;
    end

    task automatic write_byte(input byte b);
        @(negedge clk);
        #2;
        wr_en   = 1'b1;
        wr_data = b;
    endtask

    task automatic release_wr();
        @(negedge clk);
        #2;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (mc == 0 && !in_frame && dst == 0 && !wr_en) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int seed_dummy;
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; half_rate = 1'b0; dir_en = 1'b0;
        turn_delay = '0; trig_level = 7'd32; irq_en = 1'b1;
        seed_dummy = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R11 reset state
        check(txd == 1'b1, "R11 txd after reset", int'(txd), 1);
        check(hold_empty == 1'b1, "R11 hold_empty after reset", int'(hold_empty), 1);
        check(shift_empty == 1'b1, "R11 shift_empty after reset", int'(shift_empty), 1);
        check(dir_out == 1'b0, "R11 dir_out after reset", int'(dir_out), 0);
        check(ovf_pulse == 1'b0, "R11 ovf after reset", int'(ovf_pulse), 0);
        model_on = 1'b1;

        // R2 16x frames, back to back
        write_byte(8'hA5); write_byte(8'h3C); release_wr(); wait_idle();

        // R2 8x frame with sparse ticks
        half_rate = 1'b1; tick_per = 3;
        write_byte(8'h81); release_wr(); wait_idle();

        // R1 overflow with the shifter stalled
        tick_per = 0;
        for (int i = 0; i < 70; i++) write_byte(byte'(i * 7 + 1));
        release_wr();
        @(negedge clk); #1;
        check(mc == DEPTH, "R1 queue holds 64", mc, DEPTH);
        check(ovf_seen == 5, "R1 dropped writes", ovf_seen, 5);
        tick_per = 1; trig_level = 7'd20;
        wait_idle();

        // R9 delay zero, then maximum delay
        dir_en = 1'b1; turn_delay = 4'd0; half_rate = 1'b1;
        write_byte(8'h5A); release_wr(); wait_idle();
        turn_delay = 4'd15; half_rate = 1'b0;
        write_byte(8'hC3); release_wr(); wait_idle();

        // R10 write during the countdown
        turn_delay = 4'd12; half_rate = 1'b1;
        write_byte(8'h0F); release_wr();
        for (int i = 0; i < 5000 && dst != 2; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(dst == 2 && dir_out == 1'b1, "R10 in countdown", int'(dir_out), 1);
        write_byte(8'hF0); release_wr();
        @(negedge clk); #1;
        check(dir_out == 1'b1, "R10 countdown cancelled", int'(dir_out), 1);
        wait_idle();

        // constrained random mix
        for (int r = 0; r < 16; r++) begin
            half_rate  = 1'($urandom % 2);
            dir_en     = 1'($urandom % 2);
            turn_delay = 4'($urandom % 16);
            trig_level = 7'($urandom % 65);
            irq_en     = ($urandom % 4) != 0;
            tick_per   = 1 + int'($urandom % 2);
            for (int n = 0; n < 1 + int'($urandom % 6); n++) begin
                int gap;
                write_byte(8'($urandom));
                gap = int'($urandom % 40);
                if (gap > 20) begin
                    release_wr();
                    repeat (gap) @(negedge clk);
                end
            end
            release_wr();
            wait_idle();
        end
        finish_run();
    end

endmodule